// File: doc/BRIEF.md
# Machine and Supervisor Control Register Bank

This block holds the machine-level and supervisor-level control and status registers of a small 32-bit core. A single access port offers a 12-bit register address, a two-bit operation (read, write, bit-set, bit-clear), write data, read data and an illegal-access flag. The read value and the illegal flag are combinational for the access in flight. Any state change lands on the next rising clock edge.

The stored value is never the raw write data. Each access first forms a candidate value: the write data itself, or the current read value with bits set or cleared. That candidate then passes through a mask for its register. Fields that are reserved or belong to features the core lacks keep a fixed value. These include floating-point state, the user-mode endianness bit, the extension bits of the ISA register and interrupt bit 12. The supervisor status address is a restricted window onto the machine status word. The identity registers are read-only.

Top module: `csr_bank`

## Requirements
- R1: After synchronous reset the bank reads: ISA register (0x301) 0x40141105, machine status (0x300) and supervisor status (0x100) 0, interrupt enable (0x304) and interrupt delegation (0x303) 0, both counter-enable registers 0, and both cache-enable registers (0x7C0, 0x7C1) 0x00000001.
- R2: The ISA register always reads 0x40141105. That value encodes a 32-bit base and the extensions A (bit 0), C (bit 2), I (bit 8), M (bit 12), S (bit 18) and U (bit 20), one bit per letter. Writes, sets and clears to it raise no illegal flag and change nothing.
- R3: In machine status only the bits in mask 0x007E19AA are writable. Floating-point state (bits 14:13), user endianness (bit 6) and bit 31 always read 0.
- R4: A write that would put the value 2 into the previous-privilege field (bits 12:11 of machine status) leaves that field at its previous value. The other fields of the same write are still applied.
- R5: The supervisor status address (0x100) reads machine status ANDed with 0x000C0122. A write there changes only those bits of machine status.
- R6: Interrupt enable keeps only bits in 0x00000AAA and interrupt delegation keeps only bits in 0x00000222. Bit 12 of both always reads 0.
- R7: Machine counter-enable (0x306) and supervisor counter-enable (0x106) keep bits 2:0 as written and read 0 above them.
- R8: The operation code is 00 read, 01 write, 10 set and 11 clear. Set and clear build the new value from the current read value of the addressed register, OR or AND-NOT with the write data. The result then gets the same masking as a write. The result is visible in the cycle after the access.
- R9: Vendor ID (0xF11) reads 0x00000602 and architecture ID (0xF12) reads 0x00000003. Any non-read operation to an address with bits 11:10 equal to 11 raises the illegal flag and changes no state.
- R10: An access of any kind to an address the bank does not implement raises the illegal flag and changes no state.
- R11: The instruction-cache enable (0x7C0) and data-cache enable (0x7C1) registers hold bit 0 as written and read 0 in bits 31:1.
- R12: While the access enable is low, no state changes and the illegal flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_op | input | 2 | Operation: 00 read, 01 write, 10 set, 11 clear |
| acc_addr | input | 12 | Register address |
| acc_wdata | input | 32 | Write data, or the bit pattern for set and clear |
| acc_rdata | output | 32 | Current read value of the addressed register |
| acc_illegal | output | 1 | Access rejected: unimplemented address, or a modify to read-only space |

## Verification
A wrongly stored word shows up on the read port in the very next cycle that addresses it, because reads are combinational from the stored state. A bad legalization mask therefore shows up one cycle after the write, as a stray high bit in a reserved field: floating-point state, bit 12 of the interrupt registers, or bits above 2 of the counter enables. A decode slip shows up in the same cycle as the access, as a wrong illegal flag. A write that leaked through a rejected access shows up in the cycle after it, when another register reads a changed value. The reserved previous-privilege value and the supervisor window are the two paths where the new word depends on the old one, so both are tested with a non-zero prior state.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

    localparam int XLEN = 32;
    localparam int AW   = 12;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    // Stored words come first so their code doubles as storage index.
    typedef enum logic [3:0] {
        SEL_MSTATUS = 4'd0,
        SEL_MIE     = 4'd1,
        SEL_MIDELEG = 4'd2,
        SEL_MCNTEN  = 4'd3,
        SEL_SCNTEN  = 4'd4,
        SEL_ICACHE  = 4'd5,
        SEL_DCACHE  = 4'd6,
        SEL_MISA    = 4'd7,
        SEL_SSTATUS = 4'd8,
        SEL_VENDOR  = 4'd9,
        SEL_ARCH    = 4'd10,
        SEL_NONE    = 4'd15
    } csr_sel_e;

    localparam int NUM_STORED = 7;

    localparam logic [AW-1:0] ADR_SSTATUS = 12'h100;
    localparam logic [AW-1:0] ADR_SCNTEN  = 12'h106;
    localparam logic [AW-1:0] ADR_MSTATUS = 12'h300;
    localparam logic [AW-1:0] ADR_MISA    = 12'h301;
    localparam logic [AW-1:0] ADR_MIDELEG = 12'h303;
    localparam logic [AW-1:0] ADR_MIE     = 12'h304;
    localparam logic [AW-1:0] ADR_MCNTEN  = 12'h306;
    localparam logic [AW-1:0] ADR_ICACHE  = 12'h7C0;
    localparam logic [AW-1:0] ADR_DCACHE  = 12'h7C1;
    localparam logic [AW-1:0] ADR_VENDOR  = 12'hF11;
    localparam logic [AW-1:0] ADR_ARCH    = 12'hF12;

    localparam logic [XLEN-1:0] MSK_MSTATUS = 32'h007E_19AA;
    localparam logic [XLEN-1:0] MSK_SVIEW   = 32'h000C_0122;
    localparam logic [XLEN-1:0] MSK_MIE     = 32'h0000_0AAA;
    localparam logic [XLEN-1:0] MSK_MIDELEG = 32'h0000_0222;
    localparam logic [XLEN-1:0] MSK_CNTEN   = 32'h0000_0007;
    localparam logic [XLEN-1:0] MSK_CACHE   = 32'h0000_0001;

    localparam int          PRV_LO  = 11;
    localparam logic [1:0]  PRV_BAD = 2'b10;

    typedef struct packed {
        csr_sel_e sel;
        logic     hit;
        logic     ro_space;
    } csr_dec_t;

    function automatic logic [XLEN-1:0] store_mask(input csr_sel_e s);
        case (s)
            SEL_MSTATUS: return MSK_MSTATUS;
            SEL_SSTATUS: return MSK_SVIEW;
            SEL_MIE:     return MSK_MIE;
            SEL_MIDELEG: return MSK_MIDELEG;
            SEL_MCNTEN,
            SEL_SCNTEN:  return MSK_CNTEN;
            SEL_ICACHE,
            SEL_DCACHE:  return MSK_CACHE;
            default:     return '0;
        endcase
    endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_bank_pkg::*;
(
    input  logic [AW-1:0] addr,
    output csr_dec_t      dec
);
    always_comb begin
        dec.hit      = 1'b1;
        dec.ro_space = (addr[AW-1 -: 2] == 2'b11);
        case (addr)
            ADR_MSTATUS: dec.sel = SEL_MSTATUS;
            ADR_SSTATUS: dec.sel = SEL_SSTATUS;
            ADR_MISA:    dec.sel = SEL_MISA;
            ADR_MIE:     dec.sel = SEL_MIE;
            ADR_MIDELEG: dec.sel = SEL_MIDELEG;
            ADR_MCNTEN:  dec.sel = SEL_MCNTEN;
            ADR_SCNTEN:  dec.sel = SEL_SCNTEN;
            ADR_ICACHE:  dec.sel = SEL_ICACHE;
            ADR_DCACHE:  dec.sel = SEL_DCACHE;
            ADR_VENDOR:  dec.sel = SEL_VENDOR;
            ADR_ARCH:    dec.sel = SEL_ARCH;
            default: begin
                dec.sel = SEL_NONE;
                dec.hit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/csr_legalize.sv
module csr_legalize
    import csr_bank_pkg::*;
(
    input  csr_op_e         op,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] view_val,
    input  logic [XLEN-1:0] old_word,
    input  logic [XLEN-1:0] mask,
    input  logic            is_status,
    output logic [XLEN-1:0] new_word
);
    logic [XLEN-1:0] cand;
    logic [XLEN-1:0] merged;

    always_comb begin
        case (op)
            OP_WRITE: cand = wdata;
            OP_SET:   cand = view_val | wdata;
            OP_CLEAR: cand = view_val & ~wdata;
            default:  cand = view_val;
        endcase
        merged = (old_word & ~mask) | (cand & mask);
        if (is_status && merged[PRV_LO +: 2] == PRV_BAD)
            merged[PRV_LO +: 2] = old_word[PRV_LO +: 2];
        new_word = merged;
    end
endmodule

// File: rtl/csr_bank.sv
module csr_bank
    import csr_bank_pkg::*;
#(
    parameter logic [31:0] MISA_VALUE  = 32'h4014_1105,
    parameter logic [31:0] VENDOR_ID   = 32'h0000_0602,
    parameter logic [31:0] ARCH_ID     = 32'h0000_0003,
    parameter logic [31:0] CACHE_RESET = 32'h0000_0001
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_en,
    input  logic [1:0]  acc_op,
    input  logic [11:0] acc_addr,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    output logic        acc_illegal
);
    localparam int IDX_W = $clog2(NUM_STORED);

    csr_dec_t                          dec;
    csr_op_e                           op;
    logic [NUM_STORED-1:0][XLEN-1:0]   regs;
    logic [IDX_W-1:0]                  tgt_idx;
    logic                              tgt_stored;
    logic                              is_modify;
    logic                              wr_en;
    logic [XLEN-1:0]                   old_word;
    logic [XLEN-1:0]                   new_word;

    assign op = csr_op_e'(acc_op);

    csr_addr_decode u_dec (
        .addr (acc_addr),
        .dec  (dec)
    );

    // Read mux
    always_comb begin
        case (dec.sel)
            SEL_MISA:    acc_rdata = MISA_VALUE;
            SEL_VENDOR:  acc_rdata = VENDOR_ID;
            SEL_ARCH:    acc_rdata = ARCH_ID;
            SEL_SSTATUS: acc_rdata = regs[SEL_MSTATUS] & MSK_SVIEW;
            SEL_NONE:    acc_rdata = '0;
            default:     acc_rdata = regs[dec.sel[IDX_W-1:0]];
        endcase
    end

    // Write target: the supervisor window lands in the machine status word
    always_comb begin
        tgt_stored = 1'b0;
        tgt_idx    = '0;
        if (dec.sel == SEL_SSTATUS) begin
            tgt_stored = 1'b1;
            tgt_idx    = IDX_W'(SEL_MSTATUS);
        end else if (int'(dec.sel) < NUM_STORED) begin
            tgt_stored = 1'b1;
            tgt_idx    = dec.sel[IDX_W-1:0];
        end
    end

    assign is_modify   = (op != OP_READ);
    assign acc_illegal = acc_en && (!dec.hit || (is_modify && dec.ro_space));
    assign wr_en       = acc_en && is_modify && !acc_illegal && tgt_stored;
    assign old_word    = regs[tgt_idx];

    csr_legalize u_leg (
        .op        (op),
        .wdata     (acc_wdata),
        .view_val  (acc_rdata),
        .old_word  (old_word),
        .mask      (store_mask(dec.sel)),
        .is_status (tgt_idx == IDX_W'(SEL_MSTATUS)),
        .new_word  (new_word)
    );

    for (genvar g = 0; g < NUM_STORED; g++) begin : g_word
        localparam logic [XLEN-1:0] RST_VAL =
            (g == int'(SEL_ICACHE) || g == int'(SEL_DCACHE))
                ? (CACHE_RESET & MSK_CACHE) : '0;
        logic [XLEN-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= RST_VAL;
            else if (wr_en && tgt_idx == IDX_W'(g))
                q <= new_word;
        end
        assign regs[g] = q;
    end

endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk
    import csr_bank_pkg::*;
#(
    parameter logic [31:0] MISA_VALUE = 32'h4014_1105
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     acc_en,
    input logic [1:0]               acc_op,
    input logic [11:0]              acc_addr,
    input logic [31:0]              acc_wdata,
    input logic [31:0]              acc_rdata,
    input logic                     acc_illegal,
    input logic [NUM_STORED*32-1:0] regs_flat
);
    // R10
    illegal_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en && acc_illegal |=> regs_flat == $past(regs_flat));

    // R12
    idle_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_en |=> regs_flat == $past(regs_flat));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_en |-> !acc_illegal);

    // R2
    misa_const_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en && acc_addr == ADR_MISA |-> acc_rdata == MISA_VALUE && !acc_illegal);

    // R6
    irq_bit12_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en && (acc_addr == ADR_MIE || acc_addr == ADR_MIDELEG) |-> !acc_rdata[12]);

    // R3
    status_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en && (acc_addr == ADR_MSTATUS || acc_addr == ADR_SSTATUS)
        |-> acc_rdata[14:13] == 2'b00 && !acc_rdata[6] && !acc_rdata[31]);

    // R4
    prv_field_chk: assert property (@(posedge clk) disable iff (rst)
        regs_flat[PRV_LO +: 2] != PRV_BAD);

    // R9
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en && acc_op != 2'b00 && acc_addr[11:10] == 2'b11 |-> acc_illegal);

    // R7
    cnten_width_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en && (acc_addr == ADR_MCNTEN || acc_addr == ADR_SCNTEN) |-> acc_rdata[31:3] == '0);

    // R11
    icache_write_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en && acc_op == 2'b01 && acc_addr == ADR_ICACHE
        |=> regs_flat[int'(SEL_ICACHE)*32 +: 32] == {31'b0, $past(acc_wdata[0])});
endmodule

bind csr_bank csr_bank_chk #(.MISA_VALUE(MISA_VALUE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_en      (acc_en),
    .acc_op      (acc_op),
    .acc_addr    (acc_addr),
    .acc_wdata   (acc_wdata),
    .acc_rdata   (acc_rdata),
    .acc_illegal (acc_illegal),
    .regs_flat   (regs)
);

// File: tb/tb_csr_bank.sv
module tb_csr_bank;
    import csr_bank_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_en = 1'b0;
    logic [1:0]  acc_op = 2'b00;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_bank dut (
        .clk         (clk),
        .rst         (rst),
        .acc_en      (acc_en),
        .acc_op      (acc_op),
        .acc_addr    (acc_addr),
        .acc_wdata   (acc_wdata),
        .acc_rdata   (acc_rdata),
        .acc_illegal (acc_illegal)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic access(input csr_op_e op, input logic [11:0] a, input logic [31:0] d,
                          output logic [31:0] r, output logic ill);
        @(negedge clk);
        acc_en = 1'b1; acc_op = op; acc_addr = a; acc_wdata = d;
        #1;
        r   = acc_rdata;
        ill = acc_illegal;
        @(posedge clk);
        #1;
        acc_en = 1'b0;
    endtask

    task automatic expect_read(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] r; logic ill;
        access(OP_READ, a, 32'h0, r, ill);
        check(req, r, exp);
        check(req, {31'b0, ill}, 32'h0);
    endtask

    task automatic modify(input string req, input csr_op_e op, input logic [11:0] a,
                          input logic [31:0] d, input logic exp_ill);
        logic [31:0] r; logic ill;
        access(op, a, d, r, ill);
        check(req, {31'b0, ill}, {31'b0, exp_ill});
    endtask

    task automatic t_reset;
        expect_read("R1", ADR_MISA,    32'h4014_1105);
        expect_read("R1", ADR_MSTATUS, 32'h0);
        expect_read("R1", ADR_SSTATUS, 32'h0);
        expect_read("R1", ADR_MIE,     32'h0);
        expect_read("R1", ADR_MIDELEG, 32'h0);
        expect_read("R1", ADR_MCNTEN,  32'h0);
        expect_read("R1", ADR_SCNTEN,  32'h0);
        expect_read("R1", ADR_ICACHE,  32'h1);
        expect_read("R1", ADR_DCACHE,  32'h1);
    endtask

    task automatic t_status;
        modify("R3", OP_WRITE, ADR_MSTATUS, 32'hFFFF_FFFF, 1'b0);
        expect_read("R3", ADR_MSTATUS, 32'h007E_19AA);
        expect_read("R5", ADR_SSTATUS, 32'h000C_0122);
        modify("R4", OP_WRITE, ADR_MSTATUS, 32'h0000_1000, 1'b0);
        expect_read("R4", ADR_MSTATUS, 32'h0000_1800);
        modify("R4", OP_WRITE, ADR_MSTATUS, 32'h0000_0800, 1'b0);
        expect_read("R4", ADR_MSTATUS, 32'h0000_0800);
        modify("R4", OP_WRITE, ADR_MSTATUS, 32'h0000_1008, 1'b0);
        expect_read("R4", ADR_MSTATUS, 32'h0000_0808);
    endtask

    task automatic t_sview;
        modify("R5", OP_WRITE, ADR_SSTATUS, 32'hFFFF_FFFF, 1'b0);
        expect_read("R5", ADR_MSTATUS, 32'h000C_092A);
        modify("R8", OP_CLEAR, ADR_SSTATUS, 32'h0000_000A, 1'b0);
        expect_read("R8", ADR_SSTATUS, 32'h000C_0120);
        expect_read("R5", ADR_MSTATUS, 32'h000C_0928);
    endtask

    task automatic t_irq;
        modify("R6", OP_WRITE, ADR_MIE, 32'hFFFF_FFFF, 1'b0);
        expect_read("R6", ADR_MIE, 32'h0000_0AAA);
        modify("R6", OP_WRITE, ADR_MIDELEG, 32'h0000_1000, 1'b0);
        expect_read("R6", ADR_MIDELEG, 32'h0);
        modify("R6", OP_WRITE, ADR_MIDELEG, 32'h0000_FFFF, 1'b0);
        expect_read("R6", ADR_MIDELEG, 32'h0000_0222);
        modify("R8", OP_SET, ADR_MIE, 32'h0000_1000, 1'b0);
        expect_read("R8", ADR_MIE, 32'h0000_0AAA);
        modify("R8", OP_CLEAR, ADR_MIE, 32'h0000_00F0, 1'b0);
        expect_read("R8", ADR_MIE, 32'h0000_0A0A);
        modify("R8", OP_SET, ADR_MIE, 32'h0000_0080, 1'b0);
        expect_read("R8", ADR_MIE, 32'h0000_0A8A);
    endtask

    task automatic t_cnten;
        modify("R7", OP_WRITE, ADR_MCNTEN, 32'h0000_0005, 1'b0);
        expect_read("R7", ADR_MCNTEN, 32'h0000_0005);
        modify("R7", OP_WRITE, ADR_MCNTEN, 32'hFFFF_FFFF, 1'b0);
        expect_read("R7", ADR_MCNTEN, 32'h0000_0007);
        modify("R7", OP_WRITE, ADR_SCNTEN, 32'h0000_0002, 1'b0);
        expect_read("R7", ADR_SCNTEN, 32'h0000_0002);
        modify("R8", OP_CLEAR, ADR_SCNTEN, 32'h0000_0002, 1'b0);
        expect_read("R8", ADR_SCNTEN, 32'h0);
        expect_read("R7", ADR_MCNTEN, 32'h0000_0007);
    endtask

    task automatic t_misa;
        modify("R2", OP_WRITE, ADR_MISA, 32'h0, 1'b0);
        expect_read("R2", ADR_MISA, 32'h4014_1105);
        modify("R2", OP_CLEAR, ADR_MISA, 32'h0000_1005, 1'b0);
        expect_read("R2", ADR_MISA, 32'h4014_1105);
    endtask

    task automatic t_readonly;
        modify("R9", OP_WRITE, ADR_VENDOR, 32'h0, 1'b1);
        expect_read("R9", ADR_VENDOR, 32'h0000_0602);
        modify("R9", OP_SET, ADR_ARCH, 32'h0000_FFFF, 1'b1);
        expect_read("R9", ADR_ARCH, 32'h0000_0003);
    endtask

    task automatic t_unimpl;
        modify("R10", OP_READ, 12'h7C5, 32'h0, 1'b1);
        modify("R10", OP_WRITE, 12'h7C5, 32'h0, 1'b1);
        modify("R10", OP_WRITE, 12'h305, 32'hFFFF_FFFF, 1'b1);
        expect_read("R10", ADR_ICACHE, 32'h1);
        expect_read("R10", ADR_MIE, 32'h0000_0A8A);
    endtask

    task automatic t_idle;
        @(negedge clk);
        acc_en = 1'b0; acc_op = OP_WRITE; acc_addr = ADR_ICACHE; acc_wdata = 32'h0;
        #1;
        check("R12", {31'b0, acc_illegal}, 32'h0);
        @(posedge clk);
        #1;
        expect_read("R12", ADR_ICACHE, 32'h1);
    endtask

    task automatic t_cache;
        modify("R11", OP_WRITE, ADR_ICACHE, 32'h0, 1'b0);
        expect_read("R11", ADR_ICACHE, 32'h0);
        modify("R11", OP_WRITE, ADR_DCACHE, 32'hFFFF_FFFE, 1'b0);
        expect_read("R11", ADR_DCACHE, 32'h0);
        modify("R8", OP_SET, ADR_DCACHE, 32'h0000_0001, 1'b0);
        expect_read("R8", ADR_DCACHE, 32'h1);
        modify("R11", OP_WRITE, ADR_ICACHE, 32'hFFFF_FFFF, 1'b0);
        expect_read("R11", ADR_ICACHE, 32'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_status();
        t_sview();
        t_irq();
        t_cnten();
        t_misa();
        t_readonly();
        t_unimpl();
        t_idle();
        t_cache();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule